// File: doc/BRIEF.md
# Latched Fault Protection Controller

This block protects a two-phase chopper power stage. It watches two detector flags: an overcurrent comparator output and an overtemperature flag. When either flag reports a real fault, the block latches it. The latched fault holds a global output-kill line high, which forces every phase switch off, and pulls an active-low fault line to its asserted level.

Each PWM chopping period (about 50 kHz) begins with switching ringing, which can push the current comparator high for a short time. A period-start strobe therefore opens a blanking window. The window lasts a parameterised number of system-clock cycles, nominally about 5.5 µs. The overcurrent flag is ignored inside this window. Once the window has closed, the flag must also be high on two consecutive clocks before it trips, which rejects single-cycle glitches. The overtemperature flag is never blanked.

A latched fault never clears by itself. Only the power-on reset or a low-then-high pulse on the clear input removes it. A 2-bit code records which source tripped first.

Top module: `fault_guard`

## Requirements
- R1: After power-on reset (`rst_n` low), `drive_kill` is 0, `fault_n` is 1 and `trip_src` is 2'b00. An assertion of `rst_n` during operation returns the block to this state.
- R2: The overcurrent flag is ignored on the clock edge where `period_start` is sampled high and on the BLANK_CYC edges that follow it. The first edge that can count toward a trip is BLANK_CYC+1 edges after the strobe edge.
- R3: A `period_start` strobe that arrives while the window is open restarts the full blanking window. A hit that was already counted is discarded.
- R4: An overcurrent trip needs `oc_flag` high on two consecutive unblanked edges. The latch sets on the second of those edges. A single high edge, or two high edges separated by a low edge, does not trip.
- R5: `ot_flag` high on any edge with `clr_n` high trips on that same edge, whatever the state of the blanking window.
- R6: Once a fault is latched, `drive_kill` stays 1 and `fault_n` stays 0 for as long as `clr_n` is high and `rst_n` is high, whatever the flags and strobe do.
- R7: `trip_src` records the first trip: 2'b01 for overcurrent, 2'b10 for overtemperature, and 2'b11 when both trip on the same edge. Later trips do not change it.
- R8: An edge with `clr_n` low clears the latch and `trip_src`, and the block stays clear while `clr_n` is low, even with a flag high. After `clr_n` returns high, faults latch again.
- R9: `fault_n` is always the complement of `drive_kill`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous power-on reset, active low |
| clr_n | input | 1 | Synchronous fault clear, active low; a low-high pulse clears the latch |
| period_start | input | 1 | One-cycle strobe at the start of each PWM chopping period |
| oc_flag | input | 1 | Overcurrent comparator flag |
| ot_flag | input | 1 | Overtemperature flag |
| drive_kill | output | 1 | High forces all phase switches off |
| fault_n | output | 1 | Fault indication, active low |
| trip_src | output | 2 | First tripping source: 01 overcurrent, 10 overtemperature, 11 both |

## Verification
A blanking counter that is off by one shows at the ports as a trip, or a missing trip, when an overcurrent pair lands exactly on the edge where the window closes. The sweep over every offset from the strobe exposes this within one PWM period. A hit counter that is not reset by blanking or by a low flag shows up as a false trip right after a split pulse or a mid-window strobe. A latch or source register that clears by itself shows up within a few cycles, as `fault_n` rising again or `trip_src` changing while the clear input is still high.

// File: rtl/fg_pkg.sv
package fg_pkg;

  typedef enum logic [1:0] {
    SRC_NONE = 2'b00,
    SRC_OC   = 2'b01,
    SRC_OT   = 2'b10,
    SRC_BOTH = 2'b11
  } trip_src_e;

  // Bits needed to hold the values 0..n
  function automatic int cnt_width(int unsigned n);
    return (n < 2) ? 1 : $clog2(n + 1);
  endfunction

  // Source code formed from the two trip events on one edge
  function automatic trip_src_e src_code(logic oc_trip, logic ot_trip);
    return trip_src_e'({ot_trip, oc_trip});
  endfunction

endpackage

// File: rtl/fg_blank_timer.sv
module fg_blank_timer #(
  parameter int unsigned BLANK_CYC = 688,
  parameter int          CW        = fg_pkg::cnt_width(BLANK_CYC)
) (
  input  logic clk,
  input  logic rst_n,
  input  logic period_start,
  output logic blank_o
);

  localparam logic [CW-1:0] LOAD = CW'(BLANK_CYC);

  logic [CW-1:0] remain_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                remain_q <= LOAD;
    else if (period_start)     remain_q <= LOAD;
    else if (remain_q != '0)   remain_q <= remain_q - 1'b1;
  end

  assign blank_o = period_start | (remain_q != '0);

  // R3
  strobe_reblank_chk: assert property (@(posedge clk) disable iff (!rst_n)
    period_start |=> blank_o);

  // R2
  window_stays_open_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!blank_o && !period_start) |=> (!blank_o || period_start));

endmodule

// File: rtl/fg_oc_qual.sv
module fg_oc_qual #(
  parameter int unsigned CONFIRM = 2,
  parameter int          RW      = fg_pkg::cnt_width(CONFIRM)
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clr,
  input  logic blank_i,
  input  logic oc_flag,
  output logic oc_trip
);

  localparam logic [RW-1:0] LAST = RW'(CONFIRM - 1);

  logic          hit;
  logic [RW-1:0] run_q;

  assign hit     = oc_flag & ~blank_i & ~clr;
  assign oc_trip = hit & (run_q == LAST);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              run_q <= '0;
    else if (!hit)           run_q <= '0;
    else if (run_q != LAST)  run_q <= run_q + 1'b1;
  end

  // R2
  no_trip_in_blank_chk: assert property (@(posedge clk) disable iff (!rst_n)
    oc_trip |-> !blank_i);

  generate
    if (CONFIRM >= 2) begin : g_pair
      // R4
      pair_confirm_chk: assert property (@(posedge clk) disable iff (!rst_n)
        oc_trip |-> ($past(oc_flag) && !$past(blank_i) && !$past(clr)));
    end
  endgenerate

endmodule

// File: rtl/fg_trip_latch.sv
module fg_trip_latch
  import fg_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      clr,
  input  logic      oc_trip,
  input  logic      ot_trip,
  output logic      fault_q,
  output trip_src_e src_q
);

  logic any_trip;
  assign any_trip = oc_trip | ot_trip;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fault_q <= 1'b0;
      src_q   <= SRC_NONE;
    end else if (clr) begin
      fault_q <= 1'b0;
      src_q   <= SRC_NONE;
    end else if (!fault_q && any_trip) begin
      fault_q <= 1'b1;
      src_q   <= src_code(oc_trip, ot_trip);
    end
  end

  // R6
  latch_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (fault_q && !clr) |=> fault_q);

  // R7
  src_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (fault_q && !clr) |=> $stable(src_q));

  // R8
  clear_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> (!fault_q && src_q == SRC_NONE));

  // R5
  ot_sets_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ot_trip && !clr) |=> fault_q);

endmodule

// File: rtl/fault_guard.sv
module fault_guard #(
  parameter int unsigned BLANK_CYC = 688,
  parameter int unsigned CONFIRM   = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       clr_n,
  input  logic       period_start,
  input  logic       oc_flag,
  input  logic       ot_flag,
  output logic       drive_kill,
  output logic       fault_n,
  output logic [1:0] trip_src
);

  import fg_pkg::*;

  logic      clr;
  logic      blank;
  logic      oc_trip;
  logic      ot_trip;
  logic      fault_q;
  trip_src_e src_q;

  assign clr     = ~clr_n;
  assign ot_trip = ot_flag & ~clr;

  fg_blank_timer #(.BLANK_CYC(BLANK_CYC)) u_blank (
    .clk          (clk),
    .rst_n        (rst_n),
    .period_start (period_start),
    .blank_o      (blank)
  );

  fg_oc_qual #(.CONFIRM(CONFIRM)) u_qual (
    .clk     (clk),
    .rst_n   (rst_n),
    .clr     (clr),
    .blank_i (blank),
    .oc_flag (oc_flag),
    .oc_trip (oc_trip)
  );

  fg_trip_latch u_latch (
    .clk     (clk),
    .rst_n   (rst_n),
    .clr     (clr),
    .oc_trip (oc_trip),
    .ot_trip (ot_trip),
    .fault_q (fault_q),
    .src_q   (src_q)
  );

  assign drive_kill = fault_q;
  assign fault_n    = ~fault_q;
  assign trip_src   = src_q;

  // R9
  fault_pair_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fault_n != drive_kill);

  // R7
  src_iff_fault_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (trip_src != 2'b00) == drive_kill);

endmodule

// File: tb/tb_fault_guard.sv
`timescale 1ns/1ps
module tb_fault_guard;

  localparam int B = 6;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic clr_n = 1'b1;
  logic period_start = 1'b0;
  logic oc_flag = 1'b0;
  logic ot_flag = 1'b0;
  logic drive_kill, fault_n;
  logic [1:0] trip_src;

  int n_cmp = 0;
  int n_bad = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  fault_guard #(.BLANK_CYC(B), .CONFIRM(2)) dut (
    .clk(clk), .rst_n(rst_n), .clr_n(clr_n), .period_start(period_start),
    .oc_flag(oc_flag), .ot_flag(ot_flag),
    .drive_kill(drive_kill), .fault_n(fault_n), .trip_src(trip_src)
  );

  task automatic tick();
    @(negedge clk);
  endtask

  task automatic chk(string req, int act, int exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // expected state: tripped -> kill 1, fault_n 0, given code
  task automatic chk_state(string req, bit tripped, int code);
    chk({req, " kill"}, int'(drive_kill), int'(tripped));
    chk({req, " fault_n"}, int'(fault_n), int'(!tripped));
    chk({req, " src"}, int'(trip_src), tripped ? code : 0);
  endtask

  task automatic do_clear();
    clr_n = 1'b0; oc_flag = 1'b0; ot_flag = 1'b0;
    tick();
    clr_n = 1'b1;
    tick();
  endtask

  // strobe, leaving the next edge at offset 1 from the strobe edge
  task automatic strobe();
    period_start = 1'b1;
    tick();
    period_start = 1'b0;
  endtask

  // an overcurrent pair starting at offset k trips when both edges are open
  function automatic bit oc_pair_trips(int k, int blank);
    return (k >= blank + 1);
  endfunction

  initial begin
    repeat (3) tick();
    chk_state("R1 power-on", 1'b0, 0);
    rst_n = 1'b1;
    tick();
    chk_state("R1 after release", 1'b0, 0);

    // R2 sweep of pair start offset across the window
    for (int k = 1; k <= B + 4; k++) begin
      do_clear();
      strobe();
      repeat (k - 1) tick();
      oc_flag = 1'b1;
      tick(); tick();
      oc_flag = 1'b0;
      chk_state($sformatf("R2 pair offset %0d", k), oc_pair_trips(k, B), 1);
      repeat (3) tick();
      chk_state($sformatf("R6 hold offset %0d", k), oc_pair_trips(k, B), 1);
    end

    // R5 overtemperature at every offset, including inside blanking
    for (int k = 1; k <= B + 2; k++) begin
      do_clear();
      strobe();
      repeat (k - 1) tick();
      ot_flag = 1'b1;
      tick();
      ot_flag = 1'b0;
      chk_state($sformatf("R5 ot offset %0d", k), 1'b1, 2);
    end

    // R4 split and single pulses in an open window
    do_clear();
    strobe();
    repeat (B + 2) tick();
    oc_flag = 1'b1; tick(); oc_flag = 1'b0; tick();
    oc_flag = 1'b1; tick(); oc_flag = 1'b0; tick();
    chk_state("R4 split pulse", 1'b0, 0);
    oc_flag = 1'b1; tick();
    chk_state("R4 first edge", 1'b0, 0);
    tick();
    oc_flag = 1'b0;
    chk_state("R4 second edge", 1'b1, 1);

    // R3 strobe in the middle of a hit run restarts the window
    do_clear();
    strobe();
    repeat (B + 2) tick();
    oc_flag = 1'b1; tick();
    period_start = 1'b1; tick();
    period_start = 1'b0;
    repeat (B) tick();
    chk_state("R3 reblanked", 1'b0, 0);
    tick();
    chk_state("R3 first open edge", 1'b0, 0);
    tick();
    oc_flag = 1'b0;
    chk_state("R3 trip after window", 1'b1, 1);

    // R7 both sources on one edge
    do_clear();
    strobe();
    repeat (B + 2) tick();
    oc_flag = 1'b1; tick();
    ot_flag = 1'b1; tick();
    oc_flag = 1'b0; ot_flag = 1'b0;
    chk_state("R7 both", 1'b1, 3);

    // R7 first source kept when the other trips later
    do_clear();
    ot_flag = 1'b1; tick(); ot_flag = 1'b0;
    strobe();
    repeat (B + 2) tick();
    oc_flag = 1'b1; repeat (3) tick(); oc_flag = 1'b0;
    chk_state("R7 first kept", 1'b1, 2);

    // R8 flags ignored while clear is held, trip after release
    clr_n = 1'b0; ot_flag = 1'b1;
    tick();
    chk_state("R8 clear", 1'b0, 0);
    strobe();
    repeat (B + 3) begin oc_flag = 1'b1; tick(); end
    chk_state("R8 held low", 1'b0, 0);
    oc_flag = 1'b0;
    clr_n = 1'b1;
    tick();
    ot_flag = 1'b0;
    chk_state("R8 retrip", 1'b1, 2);

    // R1 reset during a latched fault
    rst_n = 1'b0;
    #1;
    chk_state("R1 mid-run reset", 1'b0, 0);
    tick();
    rst_n = 1'b1;
    tick();
    chk_state("R1 after mid-run reset", 1'b0, 0);

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_cmp++;
      n_bad++;
      $display("FAIL watchdog: actual running expected done");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

endmodule